// File: doc/BRIEF.md
# PWM Channel Enable and Interrupt Register Bank

This block is the shared control and status front end for a group of PWM channels. Software turns channels on and off by writing one-hot masks to a set register and a clear register. It gates the per-channel period-end interrupts the same way, using a second set/clear pair that holds an interrupt mask. No register needs a read-modify-write. Reading the status register returns the current channel enables. Reading the mask register returns the current interrupt mask.

Each channel counter pulses one bit of `evt_i` when its period ends. That pulse is latched into a pending register. Reading the pending register returns the latched events and clears them in the same access. A single interrupt line is raised while any pending event is unmasked. The data word is 32 bits wide, but only `NCHAN` channel bits (4 by default) are implemented. The channel counters and the clock prescalers sit outside this block and consume `chan_en_o`.

The register port is a simple single-cycle strobe interface. A write takes effect at the clock edge on which `req_i && we_i` is sampled. Read data is combinational and is valid during the `req_i && !we_i` cycle. Outside a read, `rdata_o` is zero.

Top module: `pwm_bank`

## Requirements
- R1: After an asynchronous reset (`rst_ni` low), the channel enables, interrupt mask and pending events are all zero, so `chan_en_o` is 0 and `irq_o` is 0.
- R2: A write to offset 0x04 sets every channel enable whose bit is 1 in `wdata_i[NCHAN-1:0]`. Enables whose bit is 0 keep their value. `chan_en_o` shows the change from the next clock edge onward.
- R3: A write to offset 0x08 clears every channel enable whose bit is 1 in `wdata_i`. Enables whose bit is 0 keep their value. Writing all implemented bits to 0x08 and to 0x14 stops every channel and masks every interrupt.
- R4: A read of offset 0x0C returns the channel enables in bits [NCHAN-1:0]. These bits equal `chan_en_o`. The read changes no state.
- R5: A write to offset 0x10 sets interrupt mask bits, and a write to offset 0x14 clears them, both bit-wise where `wdata_i` holds a 1. A read of offset 0x18 returns the mask in bits [NCHAN-1:0].
- R6: A 1 on `evt_i[n]` at a clock edge makes pending bit n 1. A read of offset 0x1C returns the pending bits and clears all of them at that edge. Reads of other offsets leave the pending bits unchanged.
- R7: An event that arrives on the same edge as a read of 0x1C is not returned by that read. It is still pending afterwards.
- R8: `irq_o` is 1 exactly when some pending bit has its mask bit set. It is updated from the registered state, one edge after the event or mask write.
- R9: Data bits [DATA_W-1:NCHAN] always read as 0 and are ignored on writes. Writes to 0x0C, 0x18 and 0x1C change nothing. Reads of 0x04, 0x08, 0x10, 0x14 and of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W (5) | Byte offset of the register |
| wdata_i | input | DATA_W (32) | Write data, one bit per channel |
| rdata_o | output | DATA_W (32) | Read data, combinational, zero when not reading |
| evt_i | input | NCHAN (4) | Period-end pulses from the channel counters |
| chan_en_o | output | NCHAN (4) | Channel run enables |
| irq_o | output | 1 | Combined interrupt, pending AND mask |

## Verification
The bench aims at the edge where an event coincides with a pending-register read. A design that cleared after merging would drop that event, and one that returned the new event early would report it twice. It writes ones into the upper data bits and writes to the read-only offsets. A design that stored the upper bits, or decoded too loosely, would then show stray enables or stray read data. It reads the status and mask registers between events to catch a clear-on-read that fires on the wrong offset. It also raises events on masked channels to catch an interrupt line that ignores the mask.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
  localparam int OFF_EN_SET  = 'h04;
  localparam int OFF_EN_CLR  = 'h08;
  localparam int OFF_EN_STAT = 'h0C;
  localparam int OFF_IM_SET  = 'h10;
  localparam int OFF_IM_CLR  = 'h14;
  localparam int OFF_IM_STAT = 'h18;
  localparam int OFF_PEND    = 'h1C;

  typedef struct packed {
    logic en_set;
    logic en_clr;
    logic im_set;
    logic im_clr;
    logic rd_en;
    logic rd_im;
    logic rd_pend;
  } bank_sel_t;
endpackage

// File: rtl/pwm_bank_decode.sv
module pwm_bank_decode
  import pwm_bank_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output bank_sel_t         sel_o
);
  always_comb begin
    sel_o = '0;
    if (req_i) begin
      if (we_i) begin
        case (addr_i)
          ADDR_W'(OFF_EN_SET): sel_o.en_set = 1'b1;
          ADDR_W'(OFF_EN_CLR): sel_o.en_clr = 1'b1;
          ADDR_W'(OFF_IM_SET): sel_o.im_set = 1'b1;
          ADDR_W'(OFF_IM_CLR): sel_o.im_clr = 1'b1;
          default: ;
        endcase
      end else begin
        case (addr_i)
          ADDR_W'(OFF_EN_STAT): sel_o.rd_en   = 1'b1;
          ADDR_W'(OFF_IM_STAT): sel_o.rd_im   = 1'b1;
          ADDR_W'(OFF_PEND):    sel_o.rd_pend = 1'b1;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/pwm_bank_setclr.sv
module pwm_bank_setclr #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_i,
  input  logic         clr_i,
  input  logic [W-1:0] bits_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  q_o[b] <= 1'b0;
      else if (set_i && bits_i[b])  q_o[b] <= 1'b1;
      else if (clr_i && bits_i[b])  q_o[b] <= 1'b0;
    end
  end
endmodule

// File: rtl/pwm_bank_pend.sv
module pwm_bank_pend #(
  parameter int NCHAN = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ack_i,
  input  logic [NCHAN-1:0] evt_i,
  input  logic [NCHAN-1:0] mask_i,
  output logic [NCHAN-1:0] pend_o,
  output logic             irq_o
);
  // clear first, then merge: a same-edge event survives the ack
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_o <= '0;
    else         pend_o <= (ack_i ? '0 : pend_o) | evt_i;
  end

  assign irq_o = |(pend_o & mask_i);
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int NCHAN  = 4,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [NCHAN-1:0]  evt_i,
  output logic [NCHAN-1:0]  chan_en_o,
  output logic              irq_o
);
  localparam int HI_W = DATA_W - NCHAN;

  bank_sel_t        sel;
  logic [NCHAN-1:0] wbits;
  logic [NCHAN-1:0] mask_q;
  logic [NCHAN-1:0] pend_q;
  logic             unused_wdata_hi;

  assign wbits           = wdata_i[NCHAN-1:0];
  assign unused_wdata_hi = ^wdata_i[DATA_W-1:NCHAN];

  pwm_bank_decode #(.ADDR_W(ADDR_W)) u_dec (
    .req_i (req_i),
    .we_i  (we_i),
    .addr_i(addr_i),
    .sel_o (sel)
  );

  pwm_bank_setclr #(.W(NCHAN)) u_en (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (sel.en_set),
    .clr_i (sel.en_clr),
    .bits_i(wbits),
    .q_o   (chan_en_o)
  );

  pwm_bank_setclr #(.W(NCHAN)) u_im (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (sel.im_set),
    .clr_i (sel.im_clr),
    .bits_i(wbits),
    .q_o   (mask_q)
  );

  pwm_bank_pend #(.NCHAN(NCHAN)) u_pend (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ack_i (sel.rd_pend),
    .evt_i (evt_i),
    .mask_i(mask_q),
    .pend_o(pend_q),
    .irq_o (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    if (sel.rd_en)        rdata_o = {{HI_W{1'b0}}, chan_en_o};
    else if (sel.rd_im)   rdata_o = {{HI_W{1'b0}}, mask_q};
    else if (sel.rd_pend) rdata_o = {{HI_W{1'b0}}, pend_q};
  end
endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk #(
  parameter int NCHAN  = 4,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [NCHAN-1:0]  evt_i,
  input logic [NCHAN-1:0]  chan_en_o,
  input logic              irq_o,
  input logic [NCHAN-1:0]  mask_q,
  input logic [NCHAN-1:0]  pend_q
);
  logic wr_en_set, wr_en_clr, wr_im_set, wr_im_clr, rd_stat, rd_pend;
  assign wr_en_set = req_i && we_i && addr_i == ADDR_W'('h04);
  assign wr_en_clr = req_i && we_i && addr_i == ADDR_W'('h08);
  assign wr_im_set = req_i && we_i && addr_i == ADDR_W'('h10);
  assign wr_im_clr = req_i && we_i && addr_i == ADDR_W'('h14);
  assign rd_stat   = req_i && !we_i && addr_i == ADDR_W'('h0C);
  assign rd_pend   = req_i && !we_i && addr_i == ADDR_W'('h1C);

  // R1
  always_comb if (!rst_ni) begin
    reset_idle_chk: assert (chan_en_o == '0 && !irq_o && pend_q == '0);
  end

  // R2
  en_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_set |=> (chan_en_o & $past(wdata_i[NCHAN-1:0])) == $past(wdata_i[NCHAN-1:0]));

  // R3
  en_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_clr |=> (chan_en_o & $past(wdata_i[NCHAN-1:0])) == '0);

  // R4
  stat_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_stat |-> rdata_o[NCHAN-1:0] == chan_en_o);

  // R5
  im_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_im_set |=> (mask_q & $past(wdata_i[NCHAN-1:0])) == $past(wdata_i[NCHAN-1:0]));

  // R5
  im_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_im_clr |=> (mask_q & $past(wdata_i[NCHAN-1:0])) == '0);

  // R6
  evt_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i != '0) |=> (pend_q & $past(evt_i)) == $past(evt_i));

  // R7
  ack_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_pend |=> pend_q == $past(evt_i));

  // R8
  irq_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == ((pend_q & mask_q) != '0));

  // R9
  hi_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[DATA_W-1:NCHAN] == '0);

  // R9
  en_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_set && !wr_en_clr |=> $stable(chan_en_o));
endmodule

bind pwm_bank pwm_bank_chk #(.NCHAN(NCHAN), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .rdata_o  (rdata_o),
  .evt_i    (evt_i),
  .chan_en_o(chan_en_o),
  .irq_o    (irq_o),
  .mask_q   (mask_q),
  .pend_q   (pend_q)
);

// File: tb/pwm_bank_test.sv
module pwm_bank_test;
  localparam int NCHAN  = 4;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 5;

  logic              clk = 1'b0;
  logic              rst_ni;
  logic              req_i;
  logic              we_i;
  logic [ADDR_W-1:0] addr_i;
  logic [DATA_W-1:0] wdata_i;
  logic [DATA_W-1:0] rdata_o;
  logic [NCHAN-1:0]  evt_i;
  logic [NCHAN-1:0]  chan_en_o;
  logic              irq_o;

  always #5 clk = ~clk;

  pwm_bank #(.NCHAN(NCHAN), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .evt_i(evt_i),
    .chan_en_o(chan_en_o), .irq_o(irq_o)
  );

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  // reference state
  bit [NCHAN-1:0] m_en, m_mask, m_pend;

  task automatic chk(string tag, string what, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // one bus cycle: drive at negedge, compare, then advance the model at posedge
  task automatic step(string tag, bit rq, bit w, int a, logic [DATA_W-1:0] wd, logic [NCHAN-1:0] ev);
    logic [DATA_W-1:0] exp_rd;
    @(negedge clk);
    req_i = rq; we_i = w; addr_i = ADDR_W'(a); wdata_i = wd; evt_i = ev;
    #1;
    exp_rd = '0;
    if (rq && !w) begin
      if (a == 'h0C) exp_rd = DATA_W'(m_en);
      if (a == 'h18) exp_rd = DATA_W'(m_mask);
      if (a == 'h1C) exp_rd = DATA_W'(m_pend);
    end
    chk(tag, "rdata", rdata_o, exp_rd);
    chk(tag, "chan_en", DATA_W'(chan_en_o), DATA_W'(m_en));
    chk(tag, "irq", DATA_W'(irq_o), DATA_W'((m_pend & m_mask) != 0));
    @(posedge clk);
    if (rq && w) begin
      if (a == 'h04) m_en   = m_en   |  wd[NCHAN-1:0];
      if (a == 'h08) m_en   = m_en   & ~wd[NCHAN-1:0];
      if (a == 'h10) m_mask = m_mask |  wd[NCHAN-1:0];
      if (a == 'h14) m_mask = m_mask & ~wd[NCHAN-1:0];
    end
    if (rq && !w && a == 'h1C) m_pend = '0;
    m_pend = m_pend | ev;
  endtask

  task automatic idle(string tag);
    step(tag, 1'b0, 1'b0, 0, '0, '0);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    int addrs [8];
    addrs = '{'h04, 'h08, 'h0C, 'h10, 'h14, 'h18, 'h1C, 'h00};
    m_en = '0; m_mask = '0; m_pend = '0;
    rst_ni = 1'b0; req_i = 1'b0; we_i = 1'b0; addr_i = '0; wdata_i = '0; evt_i = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "chan_en", DATA_W'(chan_en_o), '0);
    chk("R1", "irq", DATA_W'(irq_o), '0);
    rst_ni = 1'b1;
    step("R1", 1, 0, 'h1C, '0, '0);
    step("R4", 1, 0, 'h0C, '0, '0);

    // R2 set, zero bits no effect
    step("R2", 1, 1, 'h04, 32'h5, '0);
    step("R4", 1, 0, 'h0C, '0, '0);
    step("R2", 1, 1, 'h04, 32'h0, '0);
    // R9 upper bits ignored
    step("R9", 1, 1, 'h04, 32'hFFFF_FFF0, '0);
    step("R9", 1, 0, 'h0C, '0, '0);
    // R3 clear
    step("R3", 1, 1, 'h08, 32'h1, '0);
    step("R3", 1, 0, 'h0C, '0, '0);
    // R9 writes to read-only offsets ignored, write-only reads zero
    step("R9", 1, 1, 'h0C, 32'hF, '0);
    step("R9", 1, 1, 'h18, 32'hF, '0);
    step("R9", 1, 1, 'h1C, 32'hF, '0);
    step("R9", 1, 0, 'h04, '0, '0);
    step("R9", 1, 0, 'h14, '0, '0);
    step("R9", 1, 0, 'h0C, '0, '0);

    // R5 mask set / clear / readback
    step("R5", 1, 1, 'h10, 32'h3, '0);
    step("R5", 1, 0, 'h18, '0, '0);
    step("R5", 1, 1, 'h14, 32'h1, '0);
    step("R5", 1, 0, 'h18, '0, '0);

    // R8 masked event keeps irq low, unmasked raises it
    step("R8", 0, 0, 0, '0, 4'h4);
    idle("R8");
    step("R8", 0, 0, 0, '0, 4'h2);
    idle("R8");
    // R6 non-pending reads keep events
    step("R6", 1, 0, 'h0C, '0, '0);
    step("R6", 1, 0, 'h18, '0, '0);
    // R6 read returns and clears
    step("R6", 1, 0, 'h1C, '0, '0);
    step("R6", 1, 0, 'h1C, '0, '0);
    // R7 event on the read edge survives
    step("R7", 0, 0, 0, '0, 4'h8);
    step("R7", 1, 0, 'h1C, '0, 4'h2);
    step("R7", 1, 0, 'h1C, '0, '0);
    step("R7", 1, 0, 'h1C, '0, '0);

    // R3 full shutdown
    step("R3", 1, 1, 'h04, 32'hF, '0);
    step("R3", 1, 1, 'h10, 32'hF, 4'hF);
    step("R3", 1, 1, 'h08, 32'hF, '0);
    step("R3", 1, 1, 'h14, 32'hF, '0);
    step("R3", 1, 0, 'h0C, '0, '0);
    step("R3", 1, 0, 'h18, '0, '0);
    step("R3", 1, 0, 'h1C, '0, '0);

    // R8 mixed traffic
    lfsr = 32'hACE1_2461;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      step("R8", lfsr[4], lfsr[3], addrs[lfsr[2:0]], {lfsr[27:12], lfsr[31:16]},
           lfsr[13] ? lfsr[11:8] : 4'h0);
    end
    idle("R8");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule